// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer Core

This block is a 16-bit counter driven through a byte-wide register port. A control byte selects one of four counting modes and one of four prescaler divide ratios. The modes are halted, free-running over the full range, modulo against a 16-bit compare input, and a triangle sweep that climbs to the compare value and falls back to zero. The count is read as two bytes. Reading the low byte also captures the high byte into a holding register, so that a later read of the high byte matches the same moment. Writing any value to the low-byte address zeroes the whole counter.

A sticky overflow flag and three sticky channel flags live in the control byte. Hardware sets them: the overflow flag from a counter wrap or turnaround, the channel flags from external strobe inputs. Software clears a flag by writing 0 to its bit. A single interrupt request is the OR of the four flags, each gated by its own enable input.

Internally, a three-state machine sequences the counter: `ST_HALT` (no counting), `ST_UP` (ascending) and `ST_DOWN` (descending, triangle mode only). Its transitions are as follows:
- Any state goes to `ST_HALT` when the mode is halted.
- `ST_HALT` goes to `ST_UP` on the first prescaled tick in a running mode.
- `ST_UP` goes to `ST_DOWN` when the count reaches the compare value in triangle mode.
- `ST_DOWN` goes to `ST_UP` when the count leaves zero.
- A low-byte write forces `ST_UP`, or `ST_HALT` if the mode is halted.

Top module: `tmr16_core`

## Requirements
- R1: After reset the control byte reads 0x00, both count bytes read 0x00 and `irq` is low.
- R2: With mode code 00 the count holds its value.
- R3: With mode code 01, each tick advances the count by one. On the tick at 0xFFFF the count becomes 0x0000 and the overflow flag (control bit 4) is set on that same clock edge.
- R4: With mode code 10, each tick advances the count by one until the count is equal to or above `cmp0`. That tick instead loads 0x0000 and sets the overflow flag.
- R5: With mode code 11, the count climbs to `cmp0` and then descends to 0x0000. The tick that leaves 0x0000 going upward loads 0x0001 and sets the overflow flag.
- R6: With mode code 10 or 11 and `cmp0` equal to 0, a count of 0 stays 0 and the overflow flag is set on every tick.
- R7: The control bits 3:2 select the divider. Codes 00, 01, 10 and 11 give a tick every 1, 8, 32 or 128 clocks. Ticks come from a 7-bit prescaler that runs freely from reset and is never cleared by writes. With code d>0, a tick occurs when the low 2d+1 prescaler bits are all ones.
- R8: A write of any value to address 1 zeroes the count at the next edge. It overrides a coincident tick and does not set the overflow flag.
- R9: A read at address 1 returns the live low count byte and captures the current high count byte. Address 2 returns the captured byte, which resets to 0x00.
- R10: The control byte at address 0 is laid out as channel 2, 1 and 0 flags in bits 7, 6 and 5, the overflow flag in bit 4, the divider in bits 3:2 and the mode in bits 1:0. A write loads the divider and mode. A flag bit written 0 clears that flag, and a flag bit written 1 leaves it unchanged.
- R11: `ch_strobe[i]` sets control bit 5+i at the next edge. A hardware set wins over a same-cycle software clear.
- R12: `irq` is high exactly when some flag is set and its enable is high. `irq_en` bit 0 gates the overflow flag, and bits 1, 2 and 3 gate channel 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 count low, 2 count high |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; a read of address 1 captures the high byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| cmp0 | input | 16 | Compare value for modulo and triangle modes |
| ch_strobe | input | 3 | Channel flag set strobes |
| irq_en | input | 4 | Per-flag interrupt enables |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle, and that a wrap or turnaround seen one cycle later is caused by the counter and not by a coincident low-byte write. The mode and triangle properties also assume that `cmp0` does not move below the live count during a check. The random stimulus issues at most one bus operation per cycle. It changes `cmp0` only while rewriting the mode after a clear, and keeps `cmp0` small so that wraps and turnarounds occur often. Strobes, enables and divider changes are drawn freely, because the block accepts them in any cycle.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    typedef enum logic [1:0] {
        MD_HALT = 2'b00,
        MD_FREE = 2'b01,
        MD_MOD  = 2'b10,
        MD_TRI  = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        ST_HALT = 2'b00,
        ST_UP   = 2'b01,
        ST_DOWN = 2'b10
    } cstate_e;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_CLO  = 2'd1;
    localparam logic [1:0] RA_CHI  = 2'd2;

endpackage

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int NDIV  = 2 ** DIV_W;
    localparam int PRE_W = 2 * (NDIV - 1) + 1;

    logic [PRE_W-1:0] pre_q;
    logic [NDIV-1:0]  tick_opt;

    // free-running; divider writes never touch it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    for (genvar k = 0; k < NDIV; k++) begin : g_div
        localparam int SH = (k == 0) ? 0 : 2 * k + 1;
        if (SH == 0) begin : g_full
            assign tick_opt[k] = 1'b1;
        end else begin : g_part
            assign tick_opt[k] = &pre_q[SH-1:0];
        end
    end

    assign tick = tick_opt[div];

endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmode_e           mode,
    input  logic             tick,
    input  logic             clr,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    localparam logic [CNT_W-1:0] TOP_V = '1;
    localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

    cstate_e          st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             wrap_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_HALT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // next state, next count and wrap event
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        wrap_d = 1'b0;
        if (clr) begin
            cnt_d = '0;
            st_d  = (mode == MD_HALT) ? ST_HALT : ST_UP;
        end else if (mode == MD_HALT) begin
            st_d = ST_HALT;
        end else if (tick) begin
            unique case (mode)
                MD_FREE: begin
                    st_d = ST_UP;
                    if (cnt_q == TOP_V) begin
                        cnt_d  = '0;
                        wrap_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE_V;
                    end
                end
                MD_MOD: begin
                    st_d = ST_UP;
                    if (cnt_q >= cmp) begin
                        cnt_d  = '0;
                        wrap_d = 1'b1;
                    end else begin
                        cnt_d = cnt_q + ONE_V;
                    end
                end
                MD_TRI: begin
                    unique case (st_q)
                        ST_DOWN: begin
                            if (cnt_q == '0) begin
                                cnt_d  = (cmp == '0) ? '0 : ONE_V;
                                wrap_d = 1'b1;
                                st_d   = ST_UP;
                            end else begin
                                cnt_d = cnt_q - ONE_V;
                            end
                        end
                        default: begin
                            if (cnt_q == '0 && cmp == '0) begin
                                wrap_d = 1'b1;
                                st_d   = ST_UP;
                            end else if (cnt_q >= cmp) begin
                                cnt_d = cnt_q - ONE_V;
                                st_d  = ST_DOWN;
                            end else begin
                                cnt_d = cnt_q + ONE_V;
                                st_d  = ST_UP;
                            end
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = wrap_d;

endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
    import tmr16_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 2,
    parameter int NCH    = 3,
    parameter int CNT_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr,
    input  logic             rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt,
    input  logic             wrap_evt,
    input  logic [NCH-1:0]   ch_set,
    input  logic [NCH:0]     irq_en,
    output logic [BYTE_W-1:0] rdata,
    output tmode_e           mode_o,
    output logic [DIV_W-1:0] div_o,
    output logic [NCH:0]     flags_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic             irq_o
);
    localparam int DIV_LSB = 2;
    localparam int FLG_LSB = DIV_LSB + DIV_W;
    localparam int FLG_W   = NCH + 1;

    tmode_e           mode_q;
    logic [DIV_W-1:0] div_q;
    logic [FLG_W-1:0] flg_q, flg_d;
    logic [BYTE_W-1:0] hi_q;
    logic             ctrl_wr;

    assign ctrl_wr = wr && (addr == RA_CTRL);

    // sticky flags: software clears with 0, hardware set wins
    always_comb begin
        flg_d = flg_q;
        if (ctrl_wr) flg_d = flg_q & wdata[FLG_LSB +: FLG_W];
        flg_d = flg_d | {ch_set, wrap_evt};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MD_HALT;
            div_q  <= '0;
            flg_q  <= '0;
            hi_q   <= '0;
        end else begin
            flg_q <= flg_d;
            if (ctrl_wr) begin
                mode_q <= tmode_e'(wdata[1:0]);
                div_q  <= wdata[DIV_LSB +: DIV_W];
            end
            if (rd && addr == RA_CLO) hi_q <= cnt[CNT_W-1 -: BYTE_W];
        end
    end

    always_comb begin
        unique case (addr)
            RA_CTRL: rdata = {flg_q, div_q, mode_q};
            RA_CLO:  rdata = cnt[BYTE_W-1:0];
            RA_CHI:  rdata = hi_q;
            default: rdata = '0;
        endcase
    end

    assign mode_o  = mode_q;
    assign div_o   = div_q;
    assign flags_o = flg_q;
    assign hi_o    = hi_q;
    assign irq_o   = |(flg_q & irq_en);

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int DIV_W  = 2,
    parameter int NCH    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [2*BYTE_W-1:0] cmp0,
    input  logic [NCH-1:0]    ch_strobe,
    input  logic [NCH:0]      irq_en,
    output logic              irq
);
    localparam int CNT_W = 2 * BYTE_W;

    tmode_e            mode_w;
    logic [DIV_W-1:0]  div_w;
    logic              tick_w;
    logic              clr_w;
    logic              wrap_w;
    logic [CNT_W-1:0]  cnt_q;
    logic [NCH:0]      flags_w;
    logic [BYTE_W-1:0] hi_w;

    assign clr_w = bus_wr && (bus_addr == RA_CLO);

    tmr16_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (div_w),
        .tick  (tick_w)
    );

    tmr16_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode_w),
        .tick   (tick_w),
        .clr    (clr_w),
        .cmp    (cmp0),
        .cnt_o  (cnt_q),
        .wrap_o (wrap_w)
    );

    tmr16_regs #(
        .BYTE_W (BYTE_W),
        .DIV_W  (DIV_W),
        .NCH    (NCH),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .rd       (bus_rd),
        .wdata    (bus_wdata),
        .cnt      (cnt_q),
        .wrap_evt (wrap_w),
        .ch_set   (ch_strobe),
        .irq_en   (irq_en),
        .rdata    (bus_rdata),
        .mode_o   (mode_w),
        .div_o    (div_w),
        .flags_o  (flags_w),
        .hi_o     (hi_w),
        .irq_o    (irq)
    );

endmodule

// File: rtl/tmr16_core_chk.sv
module tmr16_core_chk
    import tmr16_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [15:0] cmp0,
    input logic [2:0]  ch_strobe,
    input logic [3:0]  irq_en,
    input logic        irq,
    input logic [1:0]  mode,
    input logic [1:0]  div,
    input logic        tick,
    input logic [15:0] cnt,
    input logic [3:0]  flags,
    input logic [7:0]  hi
);
    logic clr;
    assign clr = bus_wr && (bus_addr == RA_CLO);

    // R2
    a_r2_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !clr) |=> (cnt == $past(cnt)));

    // R3
    a_r3_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && tick && !clr && cnt == 16'hFFFF) |=> (cnt == 16'h0000 && flags[0]));

    // R6
    a_r6_zero_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && cmp0 == 16'h0000 && tick && !clr && cnt == 16'h0000)
        |=> (cnt == 16'h0000 && flags[0]));

    // R7
    a_r7_div1_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (div == 2'b00) |-> tick);

    // R8
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == 16'h0000));

    // R9
    a_r9_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == RA_CLO) |=> (hi == $past(cnt[15:8])));

    // R11
    a_r11_ch0_set: assert property (@(posedge clk) disable iff (!rst_n)
        ch_strobe[0] |=> flags[1]);
    a_r11_ch2_set: assert property (@(posedge clk) disable iff (!rst_n)
        ch_strobe[2] |=> flags[3]);

    // R12
    a_r12_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en == 4'b0000) |-> !irq);
    a_r12_noflag: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == 4'b0000) |-> !irq);

endmodule

bind tmr16_core tmr16_core_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .cmp0      (cmp0),
    .ch_strobe (ch_strobe),
    .irq_en    (irq_en),
    .irq       (irq),
    .mode      (mode_w),
    .div       (div_w),
    .tick      (tick_w),
    .cnt       (cnt_q),
    .flags     (flags_w),
    .hi        (hi_w)
);

// File: tb/tmr16_core_tb_top.sv
`timescale 1ns/1ps
module tmr16_core_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] cmp0 = '0;
    logic [2:0]  ch_strobe = '0;
    logic [3:0]  irq_en = '0;
    logic        irq;

    always #2 clk = ~clk;

    tmr16_core dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cmp0      (cmp0),
        .ch_strobe (ch_strobe),
        .irq_en    (irq_en),
        .irq       (irq)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    bit    chk_en = 1'b0;
    bit    done   = 1'b0;
    string dtag   = "";

    // reference model state
    logic [6:0]  m_pre;
    logic [15:0] m_cnt;
    int          m_st;      // 0 halt, 1 up, 2 down
    logic [1:0]  m_mode, m_div;
    logic [3:0]  m_flags;
    logic [7:0]  m_hi;

    function automatic logic tick_of(input logic [1:0] d, input logic [6:0] p);
        int sh;
        logic [6:0] msk;
        if (d == 2'b00) return 1'b1;
        sh  = 2 * int'(d) + 1;
        msk = 7'((1 << sh) - 1);
        return (p & msk) == msk;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0: return {m_flags, m_div, m_mode};
            2'd1: return m_cnt[7:0];
            2'd2: return m_hi;
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pre = '0; m_cnt = '0; m_st = 0;
            m_mode = '0; m_div = '0; m_flags = '0; m_hi = '0;
        end else begin
            logic        t, clr, ev;
            logic [15:0] nc;
            int          ns;
            logic [3:0]  nf;
            t   = tick_of(m_div, m_pre);
            clr = bus_wr && bus_addr == 2'd1;
            ev  = 1'b0;
            nc  = m_cnt;
            ns  = m_st;
            if (clr) begin
                nc = '0;
                ns = (m_mode == 2'b00) ? 0 : 1;
            end else if (m_mode == 2'b00) begin
                ns = 0;
            end else if (t) begin
                case (m_mode)
                    2'b01: begin
                        ns = 1;
                        if (m_cnt == 16'hFFFF) begin nc = '0; ev = 1'b1; end
                        else nc = m_cnt + 16'd1;
                    end
                    2'b10: begin
                        ns = 1;
                        if (m_cnt >= cmp0) begin nc = '0; ev = 1'b1; end
                        else nc = m_cnt + 16'd1;
                    end
                    default: begin
                        if (m_st == 2) begin
                            if (m_cnt == 16'd0) begin
                                nc = (cmp0 == 16'd0) ? 16'd0 : 16'd1;
                                ev = 1'b1;
                                ns = 1;
                            end else nc = m_cnt - 16'd1;
                        end else if (m_cnt == 16'd0 && cmp0 == 16'd0) begin
                            ev = 1'b1; ns = 1;
                        end else if (m_cnt >= cmp0) begin
                            nc = m_cnt - 16'd1; ns = 2;
                        end else begin
                            nc = m_cnt + 16'd1; ns = 1;
                        end
                    end
                endcase
            end
            nf = m_flags;
            if (bus_wr && bus_addr == 2'd0) nf = nf & bus_wdata[7:4];
            nf = nf | {ch_strobe, ev};
            if (bus_rd && bus_addr == 2'd1) m_hi = m_cnt[15:8];
            if (bus_wr && bus_addr == 2'd0) begin
                m_mode = bus_wdata[1:0];
                m_div  = bus_wdata[3:2];
            end
            m_flags = nf;
            m_cnt   = nc;
            m_st    = ns;
            m_pre   = m_pre + 7'd1;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare away from the active edge
    always @(negedge clk) begin
        if (chk_en && !done) begin
            string tg;
            if (dtag != "") tg = dtag;
            else if (bus_addr == 2'd0) tg = "R10";
            else if (bus_addr == 2'd2) tg = "R9";
            else case (m_mode)
                2'b00: tg = "R2";
                2'b01: tg = "R3";
                2'b10: tg = "R4";
                default: tg = "R5";
            endcase
            check(tg, bus_rdata, exp_rd(bus_addr));
            check((dtag != "") ? dtag : "R12", {7'd0, irq}, {7'd0, |(m_flags & irq_en)});
        end
    end

    task automatic step(input logic w, input logic r, input logic [1:0] a,
                        input logic [7:0] d, input logic [2:0] s);
        @(posedge clk);
        #1;
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; ch_strobe = s;
    endtask

    task automatic idle(input int n, input logic [1:0] a);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, a, 8'h00, 3'b000);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_en = 1'b1;

        // R1 reset state
        dtag = "R1";
        irq_en = 4'hF;
        idle(1, 2'd0);
        idle(1, 2'd1);
        idle(1, 2'd2);

        // R8 clear overrides ticking
        dtag = "R8";
        step(1'b1, 1'b0, 2'd0, 8'h01, 3'b000);
        idle(20, 2'd1);
        step(1'b1, 1'b0, 2'd1, 8'hA5, 3'b000);
        idle(3, 2'd1);
        step(1'b1, 1'b0, 2'd1, 8'h00, 3'b000);
        idle(2, 2'd0);

        // R2 halted count holds
        dtag = "R2";
        step(1'b1, 1'b0, 2'd0, 8'h00, 3'b000);
        idle(40, 2'd1);

        // R7 divider ratios; prescaler keeps running
        dtag = "R7";
        step(1'b1, 1'b0, 2'd0, 8'h05, 3'b000);
        step(1'b1, 1'b0, 2'd1, 8'h00, 3'b000);
        idle(200, 2'd1);
        step(1'b1, 1'b0, 2'd0, 8'h09, 3'b000);
        idle(300, 2'd1);
        step(1'b1, 1'b0, 2'd0, 8'h0D, 3'b000);
        idle(700, 2'd1);

        // R4 modulo
        dtag = "R4";
        cmp0 = 16'd9;
        step(1'b1, 1'b0, 2'd0, 8'h02, 3'b000);
        step(1'b1, 1'b0, 2'd1, 8'h00, 3'b000);
        idle(30, 2'd1);
        idle(3, 2'd0);

        // R5 triangle
        dtag = "R5";
        cmp0 = 16'd5;
        step(1'b1, 1'b0, 2'd0, 8'h03, 3'b000);
        step(1'b1, 1'b0, 2'd1, 8'h00, 3'b000);
        idle(40, 2'd1);
        idle(3, 2'd0);

        // R6 compare of zero
        dtag = "R6";
        cmp0 = 16'd0;
        step(1'b1, 1'b0, 2'd0, 8'h02, 3'b000);
        step(1'b1, 1'b0, 2'd1, 8'h00, 3'b000);
        for (int i = 0; i < 6; i++) begin
            step(1'b1, 1'b0, 2'd0, 8'h02, 3'b000);
            idle(2, 2'd0);
            idle(1, 2'd1);
        end
        step(1'b1, 1'b0, 2'd0, 8'h03, 3'b000);
        idle(4, 2'd0);

        // R11 strobe set wins over software clear
        dtag = "R11";
        irq_en = 4'b0010;
        step(1'b1, 1'b0, 2'd0, 8'h01, 3'b101);
        idle(2, 2'd0);
        step(1'b1, 1'b0, 2'd0, 8'h01, 3'b010);
        idle(2, 2'd0);

        // R10 writing ones leaves flags, zeros clear them
        dtag = "R10";
        step(1'b1, 1'b0, 2'd0, 8'hF1, 3'b000);
        idle(1, 2'd0);
        step(1'b1, 1'b0, 2'd0, 8'h01, 3'b000);
        idle(2, 2'd0);

        // R9 coherent high byte
        dtag = "R9";
        cmp0 = 16'hFFFF;
        step(1'b1, 1'b0, 2'd0, 8'h01, 3'b000);
        idle(700, 2'd1);
        step(1'b0, 1'b1, 2'd1, 8'h00, 3'b000);
        idle(300, 2'd1);
        idle(2, 2'd2);

        // R3 full-range wrap
        dtag = "R3";
        step(1'b1, 1'b0, 2'd0, 8'h01, 3'b000);
        step(1'b1, 1'b0, 2'd1, 8'h00, 3'b000);
        idle(65530, 2'd1);
        idle(12, 2'd0);

        // random mix
        dtag = "";
        for (int i = 0; i < 30000; i++) begin
            int op;
            logic [2:0] s;
            op = int'($urandom_range(0, 99));
            s  = ($urandom_range(0, 49) == 0) ? 3'($urandom) : 3'b000;
            if ($urandom_range(0, 199) == 0) irq_en = 4'($urandom);
            if (op < 2) begin
                cmp0 = 16'($urandom_range(0, 40));
                step(1'b1, 1'b0, 2'd0, 8'($urandom) & 8'h0F | 8'hF0, s);
                step(1'b1, 1'b0, 2'd1, 8'($urandom), 3'b000);
            end else if (op < 5) begin
                step(1'b1, 1'b0, 2'd0, {4'($urandom), m_div, m_mode}, s);
            end else if (op < 7) begin
                step(1'b1, 1'b0, 2'd1, 8'($urandom), s);
            end else if (op < 20) begin
                step(1'b0, 1'b1, 2'd1, 8'h00, s);
            end else begin
                step(1'b0, $urandom_range(0, 1) == 1 && op < 40, 2'($urandom_range(0, 2)), 8'h00, s);
            end
        end
        idle(2, 2'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule